// File: doc/BRIEF.md
# Four-Level Nested Interrupt Arbiter

This block decides which of five interrupt requests an 8-bit microcontroller core services next. The five requests come from two external lines, two timer overflows and the serial port. The serial request is the OR of its receive flag and its transmit flag. A master enable and one enable per source gate every request. Two priority registers, one holding the high bit and one the low bit, give each source one of four levels.

The block drives a registered one-cycle issue pulse. The pulse carries the vector address, the source index and the level of the winner. For every level the block keeps an in-service bit. The bit is set when that level is issued and cleared by a return-from-interrupt pulse from the core. A new request interrupts a running handler only when the request's level is strictly above every level in service. This gives up to four levels of nesting.

The registers sit behind a small write/read port. The read data is registered, so it appears one cycle after the select is presented.

Top module: `intc_top`

## Requirements
- R1: After a synchronous reset, all three registers read 0, no level is in service and no issue pulse is driven.
- R2: While the master enable (enable register bit 7) is 0, no request is issued, whatever the per-source enables and requests are.
- R3: Source indices are 0 = external line 0, 1 = timer 0, 2 = external line 1, 3 = timer 1, 4 = serial. Enable register bit i gates source i. The serial request is rx_flag OR tx_flag.
- R4: Register select 0 is the enable register, 1 is the low-priority register and 2 is the high-priority register. A source's level is {high bit i, low bit i}. reg_rdata shows the selected register one cycle after the select is presented. Bits 6:5 of the enable register and bits 7:5 of both priority registers, and select 3, read 0.
- R5: When eligible requests of different levels are pending, the one of highest level is issued.
- R6: Among eligible requests of equal level, the lowest source index is issued.
- R7: A request is issued only when its level is strictly greater than the highest level in service, or when nothing is in service. An issue is a one-cycle pulse, and from the next cycle the issued level's in-service bit is set.
- R8: A reti pulse clears the highest set in-service bit, and no issue is made in the cycle the pulse is sampled.
- R9: The issued vector is 0x0003 + 8 × source index.
- R10: A register write takes effect on arbitration from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_req | input | 4 | Requests of sources 0 to 3 |
| rx_flag | input | 1 | Serial receive flag |
| tx_flag | input | 1 | Serial transmit flag |
| reti | input | 1 | Return-from-interrupt pulse from the core |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| irq_take | output | 1 | One-cycle issue pulse |
| irq_vector | output | 16 | Vector address of the issued source |
| irq_src | output | 3 | Index of the issued source |
| irq_level | output | 2 | Level of the issued source |
| in_service | output | 4 | In-service bit per level |

## Verification
The assertions assume that reti is pulsed only by a core that has a handler running, and that a pulse with nothing in service simply does nothing. They also assume the request lines are plain levels sampled on the clock. The stimulus keeps to both: requests and flags are random levels held for whole cycles, and reti is a random sparse pulse. Register writes, including writes to the unused select and to reserved bits, are mixed in, so levels and enables change while handlers are nested.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int NUM_SRC  = 5;
  localparam int LVL_W    = 2;
  localparam int NUM_LVL  = 1 << LVL_W;
  localparam int IDX_W    = $clog2(NUM_SRC);
  localparam int REG_W    = 8;
  localparam int VEC_W    = 16;
  localparam int VEC_BASE = 3;
  localparam int VEC_STEP = 8;

  typedef enum logic [1:0] {
    SEL_ENABLE = 2'd0,
    SEL_PRI_LO = 2'd1,
    SEL_PRI_HI = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;

  function automatic logic [VEC_W-1:0] vec_of(input logic [IDX_W-1:0] idx);
    return VEC_W'(VEC_BASE) + VEC_W'(idx) * VEC_W'(VEC_STEP);
  endfunction
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  parameter int DW    = REG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [1:0]       sel,
  input  logic [DW-1:0]    wdata,
  output logic             glob_en,
  output logic [N_SRC-1:0] src_en,
  output logic [N_SRC-1:0] pri_lo,
  output logic [N_SRC-1:0] pri_hi,
  output logic [DW-1:0]    rdata
);
  localparam int PAD_EN = DW - 1 - N_SRC;
  localparam int PAD_PR = DW - N_SRC;

  logic [DW-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      glob_en <= 1'b0;
      src_en  <= '0;
      pri_lo  <= '0;
      pri_hi  <= '0;
    end else if (we) begin
      case (reg_sel_e'(sel))
        SEL_ENABLE: begin
          glob_en <= wdata[DW-1];
          src_en  <= wdata[N_SRC-1:0];
        end
        SEL_PRI_LO: pri_lo <= wdata[N_SRC-1:0];
        SEL_PRI_HI: pri_hi <= wdata[N_SRC-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_sel_e'(sel))
      SEL_ENABLE: rd_mux = {glob_en, {PAD_EN{1'b0}}, src_en};
      SEL_PRI_LO: rd_mux = {{PAD_PR{1'b0}}, pri_lo};
      SEL_PRI_HI: rd_mux = {{PAD_PR{1'b0}}, pri_hi};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/intc_arb.sv
module intc_arb
  import intc_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  parameter int LW    = LVL_W,
  parameter int IW    = IDX_W
) (
  input  logic [N_SRC-1:0] pend,
  input  logic [N_SRC-1:0] pri_lo,
  input  logic [N_SRC-1:0] pri_hi,
  output logic             any,
  output logic [IW-1:0]    best_idx,
  output logic [LW-1:0]    best_lvl
);
  logic [LW-1:0] lvl [N_SRC];

  for (genvar g = 0; g < N_SRC; g++) begin : g_lvl
    assign lvl[g] = {pri_hi[g], pri_lo[g]};
  end

  // Scan from the last index down; ">=" lets a lower index win ties.
  always_comb begin
    any      = 1'b0;
    best_idx = '0;
    best_lvl = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend[i] && (!any || lvl[i] >= best_lvl)) begin
        any      = 1'b1;
        best_idx = IW'(i);
        best_lvl = lvl[i];
      end
    end
  end
endmodule

// File: rtl/intc_lvl.sv
module intc_lvl
  import intc_pkg::*;
#(
  parameter int N_LVL = NUM_LVL,
  parameter int LW    = LVL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic [LW-1:0]    set_lvl,
  input  logic             clr_top,
  output logic [N_LVL-1:0] insvc,
  output logic             active,
  output logic [LW-1:0]    top_lvl
);
  always_comb begin
    active  = 1'b0;
    top_lvl = '0;
    for (int l = 0; l < N_LVL; l++) begin
      if (insvc[l]) begin
        active  = 1'b1;
        top_lvl = LW'(l);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      insvc <= '0;
    end else begin
      if (clr_top && active) insvc[top_lvl] <= 1'b0;
      if (set_en)            insvc[set_lvl] <= 1'b1;
    end
  end
endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int N_SRC = NUM_SRC,
  parameter int LW    = LVL_W,
  parameter int DW    = REG_W,
  parameter int VW    = VEC_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [N_SRC-2:0]      src_req,
  input  logic                  rx_flag,
  input  logic                  tx_flag,
  input  logic                  reti,
  input  logic                  reg_we,
  input  logic [1:0]            reg_sel,
  input  logic [DW-1:0]         reg_wdata,
  output logic [DW-1:0]         reg_rdata,
  output logic                  irq_take,
  output logic [VW-1:0]         irq_vector,
  output logic [$clog2(N_SRC)-1:0] irq_src,
  output logic [LW-1:0]         irq_level,
  output logic [(1<<LW)-1:0]    in_service
);
  localparam int IW    = $clog2(N_SRC);
  localparam int N_LVL = 1 << LW;

  logic             glob_en;
  logic [N_SRC-1:0] src_en, pri_lo, pri_hi;
  logic [N_SRC-1:0] raw_req, pend;
  logic             any;
  logic [IW-1:0]    best_idx;
  logic [LW-1:0]    best_lvl;
  logic             active;
  logic [LW-1:0]    top_lvl;
  logic             grant;

  intc_regs #(.N_SRC(N_SRC), .DW(DW)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .sel(reg_sel), .wdata(reg_wdata),
    .glob_en(glob_en), .src_en(src_en), .pri_lo(pri_lo), .pri_hi(pri_hi),
    .rdata(reg_rdata)
  );

  assign raw_req = {rx_flag | tx_flag, src_req};
  assign pend    = raw_req & src_en & {N_SRC{glob_en}};

  intc_arb #(.N_SRC(N_SRC), .LW(LW), .IW(IW)) u_arb (
    .pend(pend), .pri_lo(pri_lo), .pri_hi(pri_hi),
    .any(any), .best_idx(best_idx), .best_lvl(best_lvl)
  );

  assign grant = any && !reti && (!active || best_lvl > top_lvl);

  intc_lvl #(.N_LVL(N_LVL), .LW(LW)) u_lvl (
    .clk(clk), .rst(rst), .set_en(grant), .set_lvl(best_lvl), .clr_top(reti),
    .insvc(in_service), .active(active), .top_lvl(top_lvl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_take   <= 1'b0;
      irq_vector <= '0;
      irq_src    <= '0;
      irq_level  <= '0;
    end else begin
      irq_take <= grant;
      if (grant) begin
        irq_vector <= VW'(vec_of(IDX_W'(best_idx)));
        irq_src    <= best_idx;
        irq_level  <= best_lvl;
      end
    end
  end
endmodule

// File: rtl/intc_chk.sv
module intc_chk #(
  parameter int N_SRC = 5,
  parameter int LW    = 2
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      reti,
  input logic                      irq_take,
  input logic [$clog2(N_SRC)-1:0]  irq_src,
  input logic [LW-1:0]             irq_level,
  input logic [(1<<LW)-1:0]        insvc,
  input logic                      glob_en,
  input logic [N_SRC-1:0]          src_en
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> (!irq_take && insvc == '0));

  // R7
  strict_preempt_chk: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> (($past(insvc) >> irq_level) == '0));

  // R7
  level_marked_chk: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> insvc[irq_level]);

  // R8
  reti_no_issue_chk: assert property (@(posedge clk) disable iff (rst)
    reti |=> !irq_take);

  // R8
  reti_pops_one_chk: assert property (@(posedge clk) disable iff (rst)
    (reti && insvc != '0) |=> ($countones(insvc) == $countones($past(insvc)) - 1));

  // R2
  gated_issue_chk: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> ($past(glob_en) && ((($past(src_en) >> irq_src) & 1) != 0)));
endmodule

bind intc_top intc_chk #(.N_SRC(N_SRC), .LW(LW)) u_chk (
  .clk(clk), .rst(rst), .reti(reti), .irq_take(irq_take), .irq_src(irq_src),
  .irq_level(irq_level), .insvc(in_service), .glob_en(glob_en), .src_en(src_en)
);

// File: tb/test_intc_top.sv
module test_intc_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [3:0]  src_req = '0;
  logic        rx_flag = 0, tx_flag = 0, reti = 0, reg_we = 0;
  logic [1:0]  reg_sel = '0;
  logic [7:0]  reg_wdata = '0;
  logic [7:0]  reg_rdata;
  logic        irq_take;
  logic [15:0] irq_vector;
  logic [2:0]  irq_src;
  logic [1:0]  irq_level;
  logic [3:0]  in_service;

  intc_top i_intc_top (
    .clk(clk), .rst(rst), .src_req(src_req), .rx_flag(rx_flag), .tx_flag(tx_flag),
    .reti(reti), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_take(irq_take), .irq_vector(irq_vector),
    .irq_src(irq_src), .irq_level(irq_level), .in_service(in_service)
  );

  int checks = 0, errors = 0;
  logic [7:0] m_en, m_lo, m_hi;
  logic [3:0] m_isv;
  logic       e_take;
  logic [15:0] e_vec;
  logic [2:0] e_src;
  logic [1:0] e_lvl;
  logic [7:0] e_rd;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int ceiling(input logic [3:0] v);
    for (int l = 3; l >= 0; l--) if (v[l]) return l;
    return -1;
  endfunction

  task automatic model_cycle();
    logic [4:0] pend;
    int c;
    pend = {rx_flag | tx_flag, src_req} & m_en[4:0] & {5{m_en[7]}};
    c = ceiling(m_isv);
    e_take = 1'b0;
    if (!reti) begin
      for (int l = 3; l >= 0; l--) begin
        if (!e_take && l > c) begin
          for (int s = 0; s < 5; s++) begin
            if (!e_take && pend[s] && int'({m_hi[s], m_lo[s]}) == l) begin
              e_take = 1'b1;
              e_src  = 3'(s);
              e_lvl  = 2'(l);
              e_vec  = 16'(3 + 8 * s);
            end
          end
        end
      end
    end
    case (reg_sel)
      2'd0: e_rd = m_en;
      2'd1: e_rd = m_lo;
      2'd2: e_rd = m_hi;
      default: e_rd = 8'h00;
    endcase
    if (reti && c >= 0) m_isv[c] = 1'b0;
    if (e_take) m_isv[e_lvl] = 1'b1;
    if (reg_we) begin
      case (reg_sel)
        2'd0: m_en = reg_wdata & 8'h9F;
        2'd1: m_lo = reg_wdata & 8'h1F;
        2'd2: m_hi = reg_wdata & 8'h1F;
        default: ;
      endcase
    end
  endtask

  task automatic step();
    model_cycle();
    @(negedge clk);
    check("R7 take", irq_take, e_take);
    if (e_take) begin
      check("R9 vector", irq_vector, e_vec);
      check("R6 source", irq_src, e_src);
      check("R5 level", irq_level, e_lvl);
    end
    check("R8 in_service", in_service, m_isv);
    check("R4 readback", reg_rdata, e_rd);
  endtask

  task automatic drive(input logic [3:0] rq, input logic rx, input logic tx,
                       input logic rt, input logic we, input logic [1:0] sel,
                       input logic [7:0] wd);
    src_req = rq; rx_flag = rx; tx_flag = tx; reti = rt;
    reg_we = we; reg_sel = sel; reg_wdata = wd;
    step();
  endtask

  initial begin
    #3_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd2024);
    m_en = '0; m_lo = '0; m_hi = '0; m_isv = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 take", irq_take, 0);
    check("R1 in_service", in_service, 0);
    for (int s = 0; s < 3; s++) begin
      drive(4'h0, 0, 0, 0, 0, 2'(s), 8'h00);
      check("R1 register", reg_rdata, 0);
    end
    // R2: master enable off blocks everything
    drive(4'hF, 1, 1, 0, 1, 2'd0, 8'h1F);
    drive(4'hF, 1, 1, 0, 0, 2'd0, 8'h00);
    drive(4'hF, 1, 1, 0, 0, 2'd0, 8'h00);
    check("R2 blocked", irq_take, 0);
    check("R4 reserved bits", reg_rdata, 8'h1F);
    // R10: write and request in the same cycle
    drive(4'hF, 1, 1, 0, 1, 2'd0, 8'hFF);
    check("R10 not yet", irq_take, 0);
    drive(4'hF, 1, 1, 0, 0, 2'd0, 8'h00);
    check("R10 issued", irq_take, 1);
    check("R6 tie order", irq_src, 0);
    check("R9 vector", irq_vector, 16'h0003);
    drive(4'hF, 1, 1, 0, 0, 2'd0, 8'h00);
    check("R7 equal level held off", irq_take, 0);
    drive(4'h0, 0, 0, 1, 0, 2'd0, 8'h00);
    check("R8 cleared", in_service, 0);
    // R3: serial via transmit flag only
    drive(4'h0, 0, 1, 0, 0, 2'd0, 8'h00);
    check("R3 serial take", irq_take, 1);
    check("R3 serial source", irq_src, 4);
    check("R9 serial vector", irq_vector, 16'h0023);
    drive(4'h0, 0, 0, 1, 0, 2'd0, 8'h00);
    // R5: timer 1 raised to level 2 beats external line 0 at level 0
    drive(4'h0, 0, 0, 0, 1, 2'd2, 8'h08);
    drive(4'h9, 0, 0, 0, 0, 2'd2, 8'h00);
    check("R5 higher first", irq_src, 3);
    check("R5 level", irq_level, 2);
    drive(4'h9, 0, 0, 0, 0, 2'd0, 8'h00);
    check("R7 lower held off", irq_take, 0);
    // R7: external line 0 to level 3 preempts
    drive(4'h9, 0, 0, 0, 1, 2'd1, 8'h01);
    drive(4'h9, 0, 0, 0, 1, 2'd2, 8'h09);
    drive(4'h9, 0, 0, 0, 0, 2'd0, 8'h00);
    check("R7 preempt", irq_take, 1);
    check("R7 nested", in_service, 4'b1100);
    drive(4'h0, 0, 0, 1, 0, 2'd0, 8'h00);
    check("R8 pops top", in_service, 4'b0100);
    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic rt, we;
      rt = ($urandom % 8) == 0;
      we = ($urandom % 10) == 0;
      drive(4'($urandom), ($urandom % 4) == 0, ($urandom % 4) == 0, rt, we,
            2'($urandom), 8'($urandom));
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule